// File: doc/BRIEF.md
# DMA Hardware Trigger Gate

This block sits between a DMA channel sequencer and a bank of hardware event lines. It picks one event line with a selection index, brings it into the local clock domain and watches it for the configured edge. Each detected edge becomes a hit, and the block holds at most one hit at a time. The hit is spent when the sequencer asks to start a unit of work whose kind matches the configured trigger mode.

The sequencer raises a start request together with a two-bit unit kind and keeps it high until the block answers with a one-cycle go pulse. A request for the gated kind waits until a hit is available and then consumes it. A request for any other kind is answered on the next clock and leaves the stored hit alone. A second edge that arrives while a hit is still stored is dropped and raises a sticky overrun flag. Changing the selection or the polarity throws away any stored hit, so a stale event cannot release work under the new setting.

Top module: `dma_trig_gate`

## Requirements
- R1: Only the input named by `cfg_sel` produces hits. Edges on every other input have no effect.
- R2: With `cfg_pol` = 1, a low-to-high transition of the selected input produces one hit.
- R3: With `cfg_pol` = 2, a high-to-low transition produces one hit, and rising transitions produce none.
- R4: With `cfg_pol` = 0 or 3, no hit is ever produced.
- R5: A `cfg_sel` value above 55 selects no input, so no hit is produced.
- R6: The input passes through two synchroniser flops and an edge register. If a matching request is already waiting, `unit_go` goes high after the 4th rising clock edge that follows the input transition.
- R7: The unit kind uses the same encoding as the mode: 0 block, 1 repeated block, 2 linked-list item fetch, 3 single/burst. A request whose `unit_type` equals `cfg_mode` receives `unit_go` only when a hit is stored, and the go consumes that hit.
- R8: A request whose `unit_type` differs from `cfg_mode` receives `unit_go` after the first rising edge at which the request is seen, and any stored hit is kept.
- R9: An edge that arrives while a hit is stored and is not being consumed is dropped and sets `trig_overrun`. The flag stays set until reset.
- R10: Any change of `cfg_sel` or `cfg_pol` discards the stored hit.
- R11: After reset, `unit_go` and `trig_overrun` are low and no hit is stored.
- R12: `unit_go` lasts one cycle and is never high in two consecutive cycles.
- R13: Each of the four mode values gates its own unit kind and lets the other kinds pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| trig_in | input | NUM_TRIG | Asynchronous hardware event lines |
| cfg_sel | input | SEL_W | Index of the event line to watch |
| cfg_pol | input | 2 | Edge polarity: 0 off, 1 rising, 2 falling, 3 off |
| cfg_mode | input | 2 | Unit kind that must wait for a hit |
| unit_req | input | 1 | Start request, held high until go |
| unit_type | input | 2 | Kind of the requested unit |
| unit_go | output | 1 | One-cycle permission to start the unit |
| trig_overrun | output | 1 | Sticky flag: an edge was dropped |

## Verification
The bench builds the block with its default 56 event lines and a 6-bit index. This lets it drive selection values both inside and beyond the valid range: index 5 is the active line, index 6 is a neighbour that must be ignored, and index 60 points at no input. The bench runs all four mode values, so every pairing of gated and passing unit kinds occurs. The two-flop synchroniser depth fixes the input-to-go latency that the bench schedules its expected pulses against.

// File: rtl/dma_trig_pkg.sv
package dma_trig_pkg;

  typedef enum logic [1:0] {
    POL_OFF     = 2'd0,
    POL_RISE    = 2'd1,
    POL_FALL    = 2'd2,
    POL_OFF_ALT = 2'd3
  } trig_pol_e;

  typedef enum logic [1:0] {
    UNIT_BLOCK  = 2'd0,
    UNIT_REPEAT = 2'd1,
    UNIT_LINK   = 2'd2,
    UNIT_BURST  = 2'd3
  } unit_kind_e;

  localparam int SYNC_STAGES = 2;

endpackage

// File: rtl/dma_trig_sync.sv
module dma_trig_sync #(
  parameter int WIDTH  = 56,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_line
    logic [STAGES-1:0] shift_q;
    logic [STAGES-1:0] shift_d;

    always_comb begin
      shift_d = {shift_q[STAGES-2:0], async_in[g]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shift_q <= '0;
      end else begin
        shift_q <= shift_d;
      end
    end

    assign sync_out[g] = shift_q[STAGES-1];
  end

endmodule

// File: rtl/dma_trig_edge.sv
module dma_trig_edge
  import dma_trig_pkg::*;
#(
  parameter int NUM_TRIG = 56,
  parameter int SEL_W    = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_TRIG-1:0] line_sync,
  input  logic [SEL_W-1:0]    sel,
  input  logic [1:0]          pol,
  output logic                hit,
  output logic                cfg_chg
);

  localparam logic [SEL_W-1:0] LAST_IDX = SEL_W'(NUM_TRIG - 1);

  logic             cur;
  logic             prev_q;
  logic [SEL_W-1:0] sel_q;
  logic [1:0]       pol_q;
  logic             rise;
  logic             fall;

  // Line selection; an index past the last line selects a constant low.
  always_comb begin
    if (sel <= LAST_IDX) begin
      cur = line_sync[sel];
    end else begin
      cur = 1'b0;
    end
  end

  always_comb begin
    cfg_chg = (sel != sel_q) || (pol != pol_q);
    rise    = cur && !prev_q;
    fall    = !cur && prev_q;
    hit     = 1'b0;
    if (!cfg_chg) begin
      unique case (trig_pol_e'(pol))
        POL_RISE: hit = rise;
        POL_FALL: hit = fall;
        default:  hit = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      sel_q  <= '0;
      pol_q  <= 2'd0;
    end else begin
      prev_q <= cur;
      sel_q  <= sel;
      pol_q  <= pol;
    end
  end

  // An index change must not let the level of the old line fake an edge
  AST_NO_HIT_ON_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
    (sel != $past(sel)) |-> !hit); // R10

endmodule

// File: rtl/dma_trig_latch.sv
module dma_trig_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic clr,
  input  logic consume,
  output logic pend,
  output logic overrun
);

  logic pend_q;
  logic pend_d;
  logic ovr_q;
  logic ovr_d;

  always_comb begin
    pend_d = pend_q;
    ovr_d  = ovr_q;
    if (clr) begin
      pend_d = 1'b0;
    end else if (consume) begin
      pend_d = hit;
    end else if (hit) begin
      pend_d = 1'b1;
      if (pend_q) begin
        ovr_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      ovr_q  <= ovr_d;
    end
  end

  assign pend    = pend_q;
  assign overrun = ovr_q;

  AST_PEND_FROM_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(hit)); // R7
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q |=> ovr_q); // R9
  AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_q) |-> $past(hit && pend_q)); // R9
  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !pend_q); // R10

endmodule

// File: rtl/dma_trig_release.sv
module dma_trig_release
  import dma_trig_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req,
  input  logic [1:0] kind,
  input  logic [1:0] mode,
  input  logic       pend,
  output logic       go,
  output logic       consume
);

  logic       go_q;
  logic       go_d;
  logic       gated;
  unit_kind_e kind_e;
  unit_kind_e mode_e;

  always_comb begin
    kind_e  = unit_kind_e'(kind);
    mode_e  = unit_kind_e'(mode);
    gated   = (kind_e == mode_e);
    go_d    = req && !go_q && (!gated || pend);
    consume = go_d && gated;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go_q <= 1'b0;
    end else begin
      go_q <= go_d;
    end
  end

  assign go = go_q;

  AST_GO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    go_q |=> !go_q); // R12
  AST_GO_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    go_q |-> $past(req)); // R8
  AST_MATCH_WAITS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (go_q && $past(kind == mode)) |-> $past(pend)); // R7

endmodule

// File: rtl/dma_trig_gate.sv
module dma_trig_gate
  import dma_trig_pkg::*;
#(
  parameter int NUM_TRIG = 56,
  parameter int SEL_W    = $clog2(NUM_TRIG)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_TRIG-1:0] trig_in,
  input  logic [SEL_W-1:0]    cfg_sel,
  input  logic [1:0]          cfg_pol,
  input  logic [1:0]          cfg_mode,
  input  logic                unit_req,
  input  logic [1:0]          unit_type,
  output logic                unit_go,
  output logic                trig_overrun
);

  localparam logic [SEL_W-1:0] LAST_IDX = SEL_W'(NUM_TRIG - 1);

  logic                rst_meta_q;
  logic                rst_sync_q;
  logic                rst_int_n;
  logic [NUM_TRIG-1:0] line_sync;
  logic                hit;
  logic                cfg_chg;
  logic                pend;
  logic                consume;

  // Reset: asserted at once, removed on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end
  assign rst_int_n = rst_sync_q;

  dma_trig_sync #(
    .WIDTH  (NUM_TRIG),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .async_in (trig_in),
    .sync_out (line_sync)
  );

  dma_trig_edge #(
    .NUM_TRIG (NUM_TRIG),
    .SEL_W    (SEL_W)
  ) u_edge (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .line_sync (line_sync),
    .sel       (cfg_sel),
    .pol       (cfg_pol),
    .hit       (hit),
    .cfg_chg   (cfg_chg)
  );

  dma_trig_latch u_latch (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .hit     (hit),
    .clr     (cfg_chg),
    .consume (consume),
    .pend    (pend),
    .overrun (trig_overrun)
  );

  dma_trig_release u_rel (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .req     (unit_req),
    .kind    (unit_type),
    .mode    (cfg_mode),
    .pend    (pend),
    .go      (unit_go),
    .consume (consume)
  );

  AST_MASK_NO_PEND: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(pend) |-> $past(cfg_pol == POL_RISE || cfg_pol == POL_FALL)); // R4
  AST_RANGE_NO_PEND: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(pend) |-> $past(cfg_sel <= LAST_IDX)); // R5
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_int_n |-> (!unit_go && !trig_overrun)); // R11

endmodule

// File: tb/dma_trig_gate_bench.sv
module dma_trig_gate_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_TRIG   = 56;
  localparam int SEL_W      = 6;

  logic                clk;
  logic                rst_n;
  logic [NUM_TRIG-1:0] trig;
  logic [SEL_W-1:0]    cfg_sel;
  logic [1:0]          cfg_pol;
  logic [1:0]          cfg_mode;
  logic                unit_req;
  logic [1:0]          unit_type;
  logic                unit_go;
  logic                trig_overrun;

  int    cyc;
  int    checks;
  int    fails;
  bit    got_go;
  bit    done;
  int    q_cyc[$];
  string q_tag[$];
  string cur_tag;
  int    mon_exp;
  string mon_tag;

  dma_trig_gate #(
    .NUM_TRIG (NUM_TRIG),
    .SEL_W    (SEL_W)
  ) u_dma_trig_gate (
    .clk          (clk),
    .rst_n        (rst_n),
    .trig_in      (trig),
    .cfg_sel      (cfg_sel),
    .cfg_pol      (cfg_pol),
    .cfg_mode     (cfg_mode),
    .unit_req     (unit_req),
    .unit_type    (unit_type),
    .unit_go      (unit_go),
    .trig_overrun (trig_overrun)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Scoreboard monitor: every go pulse is matched against the expected queue
  always @(negedge clk) begin
    if (rst_n && unit_go) begin
      got_go = 1'b1;
      checks++;
      if (q_cyc.size() == 0) begin
        fails++;
        $display("FAIL %s: unexpected go at cycle %0d (expected none)", cur_tag, cyc);
      end else begin
        mon_exp = q_cyc.pop_front();
        mon_tag = q_tag.pop_front();
        if (cyc != mon_exp) begin
          fails++;
          $display("FAIL %s: go at cycle %0d, expected %0d", mon_tag, cyc, mon_exp);
        end
      end
    end
  end

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic check_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d, expected %0d", tag, act, exp);
    end
  endtask

  task automatic expect_at(input string tag, input int c);
    q_cyc.push_back(c);
    q_tag.push_back(tag);
  endtask

  task automatic req_on(input int kind);
    unit_type = 2'(kind);
    unit_req  = 1'b1;
  endtask

  task automatic wait_go(input string tag);
    int n;
    n = 0;
    cur_tag = tag;
    while (!got_go && n < 60) begin
      tick();
      n++;
    end
    checks++;
    if (!got_go) begin
      fails++;
      $display("FAIL %s: go missing, got 0 expected 1", tag);
    end
    unit_req = 1'b0;
    got_go   = 1'b0;
    tick();
    check_eq({tag, "/R12"}, int'(unit_go), 0);
  endtask

  // No go may appear in the window; the monitor reports any that does.
  task automatic quiet(input string tag, input int n);
    cur_tag = tag;
    tick(n);
    checks++;
    got_go = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    checks    = 0;
    fails     = 0;
    got_go    = 1'b0;
    done      = 1'b0;
    cur_tag   = "init";
    rst_n     = 1'b0;
    trig      = '0;
    cfg_sel   = 6'd5;
    cfg_pol   = 2'd1;
    cfg_mode  = 2'd0;
    unit_req  = 1'b0;
    unit_type = 2'd0;
    tick(3);
    rst_n = 1'b1;
    tick(4);

    // R11: reset state, nothing stored
    check_eq("R11 go", int'(unit_go), 0);
    check_eq("R11 overrun", int'(trig_overrun), 0);
    req_on(0);
    quiet("R11", 6);

    // R2 and R6: rising edge releases a waiting block request four edges later
    trig[5] = 1'b1;
    expect_at("R6", cyc + 4);
    wait_go("R2");

    // R7: the hit was consumed; R1: neighbour line ignored
    tick(3);
    trig[5] = 1'b0;
    tick(3);
    req_on(0);
    quiet("R7", 8);
    trig[6] = 1'b1;
    quiet("R1", 6);
    trig[6] = 1'b0;
    tick(2);
    trig[5] = 1'b1;
    expect_at("R7", cyc + 4);
    wait_go("R7");

    // R8: other kinds pass at once and keep the stored hit
    tick(2);
    trig[5] = 1'b0;
    tick(3);
    trig[5] = 1'b1;
    tick(5);
    req_on(1);
    expect_at("R8", cyc + 1);
    wait_go("R8");
    req_on(0);
    expect_at("R8 kept", cyc + 1);
    wait_go("R8");

    // R3: falling polarity
    cfg_pol = 2'd2;
    tick(4);
    req_on(0);
    quiet("R3", 3);
    trig[5] = 1'b0;
    expect_at("R3", cyc + 4);
    wait_go("R3");
    req_on(0);
    trig[5] = 1'b1;
    quiet("R3 rise", 6);
    trig[5] = 1'b0;
    expect_at("R3", cyc + 4);
    wait_go("R3");

    // R4: polarity 0 and 3 mask the line
    cfg_pol = 2'd0;
    tick(3);
    req_on(0);
    trig[5] = 1'b1; tick(3); trig[5] = 1'b0; tick(3);
    quiet("R4 pol0", 4);
    cfg_pol = 2'd3;
    tick(2);
    trig[5] = 1'b1; tick(3); trig[5] = 1'b0; tick(3);
    quiet("R4 pol3", 4);
    cfg_pol = 2'd1;
    tick(3);
    trig[5] = 1'b1;
    expect_at("R4", cyc + 4);
    wait_go("R4");

    // R5: index beyond the last line selects nothing
    trig[5] = 1'b0;
    tick(3);
    cfg_sel = 6'd60;
    tick(3);
    req_on(0);
    trig = '1; tick(3); trig = '0; tick(3);
    quiet("R5", 4);
    cfg_sel = 6'd5;
    tick(3);
    trig[5] = 1'b1;
    expect_at("R5", cyc + 4);
    wait_go("R5");

    // R9: second edge while a hit is stored is dropped and flagged
    tick(2);
    check_eq("R9 clear", int'(trig_overrun), 0);
    trig[5] = 1'b0; tick(3);
    trig[5] = 1'b1; tick(3);
    trig[5] = 1'b0; tick(3);
    trig[5] = 1'b1; tick(6);
    check_eq("R9 set", int'(trig_overrun), 1);
    req_on(0);
    expect_at("R9", cyc + 1);
    wait_go("R9");
    req_on(0);
    quiet("R9 dropped", 8);
    check_eq("R9 sticky", int'(trig_overrun), 1);
    trig[5] = 1'b0; tick(3);
    trig[5] = 1'b1;
    expect_at("R9", cyc + 4);
    wait_go("R9");

    // R10: a configuration change discards the stored hit
    trig[5] = 1'b0; tick(3);
    trig[5] = 1'b1; tick(5);
    cfg_sel = 6'd6;
    tick();
    cfg_sel = 6'd5;
    tick(3);
    req_on(0);
    quiet("R10", 6);
    trig[5] = 1'b0; tick(3);
    trig[5] = 1'b1;
    expect_at("R10", cyc + 4);
    wait_go("R10");

    // R13: every mode gates its own kind only
    for (int m = 1; m < 4; m++) begin
      cfg_mode = 2'(m);
      trig[5] = 1'b0;
      tick(3);
      req_on(m);
      quiet("R13 wait", 4);
      trig[5] = 1'b1;
      expect_at("R13 gated", cyc + 4);
      wait_go("R13");
      req_on(0);
      expect_at("R13 pass", cyc + 1);
      wait_go("R13");
    end

    tick(3);
    check_eq("R13 queue empty", q_cyc.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule